// File: doc/BRIEF.md
# Issue-Stepped Operation Pipelines

This block holds four independent operation pipelines: adder, multiplier, graphics and load. A pipeline does not advance on every clock. It moves only when its own issue strobe is high. On each issue it takes two source operands and a status tag into its first stage and shifts every stage forward by one. The entry that falls out of the last stage is returned as a result for the destination-register write port, and its tag is returned for the status-register port. As a result, each issue retires the work of an earlier issue to the same pipeline, and how far back that issue lies depends on the pipeline's depth.

The depths are as follows. The adder and load pipelines have three stages. The graphics pipeline has one stage. The multiplier has three stages when its source operands are single precision and two stages when they are double precision. The multiplier depth is taken from the precision code presented with each issue. Each stage holds a valid flag, an intermediate value and the status tag that came in with the operation. The computation inside the stages is a placeholder: the first stage adds the two operands and later stages pass their value through unchanged.

All outputs are registered. The results of an issue sampled at a clock edge are visible just after that edge.

Top module: `issue_pipe_set`

## Requirements
- R1: During and after reset, with no issue yet, every result, status, write enable and status-update output is zero.
- R2: On a clock where a pipeline's issue strobe is low, its write enable and status-update outputs are low, its result and status outputs keep their previous values, and none of its stages change. Later returns show that the stages were unchanged.
- R3: The adder is pipeline index 0 (bit 0 of each strobe vector, lane 0 of each packed bus). Each adder issue returns the operation of the third prior adder issue.
- R4: The multiplier is index 1. Precision code bit pattern 00 means single in and single out, and 01 means single in and double out. With either code, a multiplier issue returns the third prior multiplier issue.
- R5: Precision code 11 means double in and double out, and 10 means double in and single out. With either code, the multiplier has two stages and an issue returns the second prior multiplier issue.
- R6: When the multiplier's source precision changes between issues, the new issue's depth applies. Going from three stages to two returns the entry in stage 2. Going from two stages to three finds stage 3 empty, so it returns result zero, status zero and write enable low.
- R7: The graphics pipeline is index 2. Each graphics issue returns the immediately preceding graphics issue.
- R8: The load pipeline is index 3. Each load issue returns the third prior load issue, whatever the precision code.
- R9: An issue whose returned entry is not valid (the pipeline is not yet filled, or the entry is empty) drives write enable low and result and status zero. A valid returned entry drives write enable high for exactly one clock.
- R10: A valid returned result equals operand A plus operand B modulo 2^DW of the originating issue, and its status equals that issue's tag unchanged.
- R11: Each pipeline advances only on its own strobe. Issuing to any mix of the other pipelines never changes its contents.
- R12: The status-update output of a pipeline pulses high for one clock after every issue to it, whether or not the returned entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | NPIPE | Per-pipeline issue strobe (0 adder, 1 mul, 2 graphics, 3 load) |
| opa_i | input | NPIPE*DW | Operand A, one DW lane per pipeline |
| opb_i | input | NPIPE*DW | Operand B, one DW lane per pipeline |
| tag_i | input | NPIPE*TW | Status tag entering with each issue |
| mul_prec_i | input | 2 | Multiplier precision code for the current issue |
| res_o | output | NPIPE*DW | Returned result per pipeline |
| wr_en_o | output | NPIPE | Destination write enable per pipeline |
| stat_o | output | NPIPE*TW | Returned status per pipeline |
| stat_upd_o | output | NPIPE | Status-register update pulse per pipeline |

## Verification
The assertions assume that the precision code is stable during any clock on which the multiplier strobe is high. They also assume that operand and tag lanes matter only while their strobe is high. The stimulus drives every input at the falling edge and holds it through the next rising edge. It uses directed sequences to fill each pipeline, sit idle, and switch the multiplier precision both ways. It then issues random strobe masks with random codes, so that depth transitions and partial issue sets occur often.

// File: rtl/ipipe_pkg.sv
package ipipe_pkg;

    localparam int NPIPE    = 4;
    localparam int PIPE_ADD = 0;
    localparam int PIPE_MUL = 1;
    localparam int PIPE_GFX = 2;
    localparam int PIPE_LD  = 3;

    typedef enum logic [1:0] {
        PREC_SS = 2'b00,
        PREC_SD = 2'b01,
        PREC_DS = 2'b10,
        PREC_DD = 2'b11
    } prec_e;

    function automatic logic src_is_double(input logic [1:0] code);
        return (code == PREC_DS) || (code == PREC_DD);
    endfunction

endpackage

// File: rtl/ipipe_chain.sv
module ipipe_chain #(
    parameter int DW        = 16,
    parameter int TW        = 4,
    parameter int DEPTH     = 3,
    parameter bit SHORTABLE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [TW-1:0] tag_i,
    input  logic          short_i,
    output logic          out_vld_o,
    output logic [DW-1:0] out_val_o,
    output logic [TW-1:0] out_tag_o
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] val;
        logic [TW-1:0] tag;
    } stage_t;

    localparam int EFF_MIN = (SHORTABLE && DEPTH > 1) ? DEPTH - 1 : DEPTH;

    stage_t st_q [DEPTH];
    stage_t st_d [DEPTH];
    stage_t leave;
    logic   short_eff;

    assign short_eff = SHORTABLE && short_i && (EFF_MIN < DEPTH);

    // Slot that leaves the pipeline at this issue.
    always_comb begin
        leave = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (short_eff ? (i == DEPTH - 2) : (i == DEPTH - 1)) begin
                leave = st_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            st_d[i] = st_q[i];
        end
        if (issue_i) begin
            st_d[0].vld = 1'b1;
            st_d[0].val = opa_i + opb_i;
            st_d[0].tag = tag_i;
            for (int i = 1; i < DEPTH; i++) begin
                st_d[i] = st_q[i-1];
            end
            if (short_eff && DEPTH > 1) begin
                st_d[DEPTH-1] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) st_q[i] <= '0;
            else        st_q[i] <= st_d[i];
        end
    end

    assign out_vld_o = leave.vld;
    assign out_val_o = leave.val;
    assign out_tag_o = leave.tag;

    AST_FIRST_STAGE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> st_q[0].vld && st_q[0].tag == $past(tag_i)); // R10

    generate
        if (DEPTH > 1) begin : g_shift_chk
            AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_i && !short_eff) |=> st_q[1] == $past(st_q[0])); // R3
        end
        if (SHORTABLE && DEPTH > 1) begin : g_short_chk
            AST_SHORT_TAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_i && short_eff) |=> !st_q[DEPTH-1].vld); // R6
        end
    endgenerate

endmodule

// File: rtl/ipipe_retire.sv
module ipipe_retire #(
    parameter int DW = 16,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic          leave_vld_i,
    input  logic [DW-1:0] leave_val_i,
    input  logic [TW-1:0] leave_tag_i,
    output logic [DW-1:0] res_o,
    output logic          wr_en_o,
    output logic [TW-1:0] stat_o,
    output logic          stat_upd_o
);

    typedef struct packed {
        logic [DW-1:0] res;
        logic [TW-1:0] stat;
        logic          we;
        logic          upd;
    } ret_t;

    ret_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.upd = 1'b0;
        if (issue_i) begin
            r_d.upd  = 1'b1;
            r_d.we   = leave_vld_i;
            r_d.res  = leave_vld_i ? leave_val_i : '0;
            r_d.stat = leave_vld_i ? leave_tag_i : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_o      = r_q.res;
    assign stat_o     = r_q.stat;
    assign wr_en_o    = r_q.we;
    assign stat_upd_o = r_q.upd;

    AST_WE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(issue_i)); // R9
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> stat_upd_o); // R12
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> $stable(res_o) && $stable(stat_o) && !wr_en_o); // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_upd_o && !wr_en_o) |-> (res_o == '0 && stat_o == '0)); // R9

endmodule

// File: rtl/issue_pipe_set.sv
module issue_pipe_set
    import ipipe_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TW        = 4,
    parameter int ADD_DEPTH = 3,
    parameter int MUL_DEPTH = 3,
    parameter int GFX_DEPTH = 1,
    parameter int LD_DEPTH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPIPE-1:0]    issue_i,
    input  logic [NPIPE*DW-1:0] opa_i,
    input  logic [NPIPE*DW-1:0] opb_i,
    input  logic [NPIPE*TW-1:0] tag_i,
    input  logic [1:0]          mul_prec_i,
    output logic [NPIPE*DW-1:0] res_o,
    output logic [NPIPE-1:0]    wr_en_o,
    output logic [NPIPE*TW-1:0] stat_o,
    output logic [NPIPE-1:0]    stat_upd_o
);

    logic mul_short;
    assign mul_short = src_is_double(mul_prec_i);

    generate
        for (genvar k = 0; k < NPIPE; k++) begin : g_pipe
            localparam int DEP = (k == PIPE_ADD) ? ADD_DEPTH :
                                 (k == PIPE_MUL) ? MUL_DEPTH :
                                 (k == PIPE_GFX) ? GFX_DEPTH : LD_DEPTH;
            localparam bit SHR = (k == PIPE_MUL);

            logic          lv_vld;
            logic [DW-1:0] lv_val;
            logic [TW-1:0] lv_tag;
            logic          short_k;

            assign short_k = SHR ? mul_short : 1'b0;

            ipipe_chain #(
                .DW(DW), .TW(TW), .DEPTH(DEP), .SHORTABLE(SHR)
            ) u_chain (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue_i   (issue_i[k]),
                .opa_i     (opa_i[k*DW +: DW]),
                .opb_i     (opb_i[k*DW +: DW]),
                .tag_i     (tag_i[k*TW +: TW]),
                .short_i   (short_k),
                .out_vld_o (lv_vld),
                .out_val_o (lv_val),
                .out_tag_o (lv_tag)
            );

            ipipe_retire #(
                .DW(DW), .TW(TW)
            ) u_ret (
                .clk         (clk),
                .rst_n       (rst_n),
                .issue_i     (issue_i[k]),
                .leave_vld_i (lv_vld),
                .leave_val_i (lv_val),
                .leave_tag_i (lv_tag),
                .res_o       (res_o[k*DW +: DW]),
                .wr_en_o     (wr_en_o[k]),
                .stat_o      (stat_o[k*TW +: TW]),
                .stat_upd_o  (stat_upd_o[k])
            );
        end
    endgenerate

    AST_STROBE_SEPARATION: assert property (@(posedge clk) disable iff (!rst_n)
        stat_upd_o == $past(issue_i)); // R11

endmodule

// File: tb/issue_pipe_set_tb.sv
module issue_pipe_set_tb;

    localparam int NP = 4;
    localparam int DW = 16;
    localparam int TW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    issue_i = '0;
    logic [NP*DW-1:0] opa_i = '0;
    logic [NP*DW-1:0] opb_i = '0;
    logic [NP*TW-1:0] tag_i = '0;
    logic [1:0]       mul_prec_i = 2'b00;
    logic [NP*DW-1:0] res_o;
    logic [NP-1:0]    wr_en_o;
    logic [NP*TW-1:0] stat_o;
    logic [NP-1:0]    stat_upd_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic          m_v [NP][3];
    logic [DW-1:0] m_r [NP][3];
    logic [TW-1:0] m_t [NP][3];
    logic [DW-1:0] e_res [NP];
    logic [TW-1:0] e_stat [NP];
    logic          e_we [NP];
    string         e_lab [NP];
    int            last_mul_d = 3;

    always #5 clk = ~clk;

    issue_pipe_set u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .tag_i      (tag_i),
        .mul_prec_i (mul_prec_i),
        .res_o      (res_o),
        .wr_en_o    (wr_en_o),
        .stat_o     (stat_o),
        .stat_upd_o (stat_upd_o)
    );

    function automatic int depth_of(input int k, input logic [1:0] p);
        if (k == 0) return 3;
        if (k == 1) return p[1] ? 2 : 3;
        if (k == 2) return 1;
        return 3;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [NP-1:0] mask, input logic [1:0] p);
        issue_i    = mask;
        mul_prec_i = p;
        for (int k = 0; k < NP; k++) begin
            logic [DW-1:0] a;
            logic [DW-1:0] b;
            logic [TW-1:0] t;
            int            d;
            a = DW'($urandom);
            b = DW'($urandom);
            t = TW'($urandom);
            opa_i[k*DW +: DW] = a;
            opb_i[k*DW +: DW] = b;
            tag_i[k*TW +: TW] = t;
            if (mask[k]) begin
                d = depth_of(k, p);
                e_we[k]   = m_v[k][d-1];
                e_res[k]  = m_v[k][d-1] ? m_r[k][d-1] : '0;
                e_stat[k] = m_v[k][d-1] ? m_t[k][d-1] : '0;
                if (k == 0) e_lab[k] = "R3";
                else if (k == 2) e_lab[k] = "R7";
                else if (k == 3) e_lab[k] = "R8";
                else begin
                    if (d != last_mul_d) e_lab[k] = "R6";
                    else if (d == 2)     e_lab[k] = "R5";
                    else                 e_lab[k] = "R4";
                    last_mul_d = d;
                end
                for (int i = 2; i >= 1; i--) begin
                    m_v[k][i] = m_v[k][i-1];
                    m_r[k][i] = m_r[k][i-1];
                    m_t[k][i] = m_t[k][i-1];
                end
                m_v[k][0] = 1'b1;
                m_r[k][0] = a + b;
                m_t[k][0] = t;
                if (k == 1 && d == 2) begin
                    m_v[k][2] = 1'b0;
                    m_r[k][2] = '0;
                    m_t[k][2] = '0;
                end
            end else begin
                e_we[k] = 1'b0;
            end
        end
        @(negedge clk);
        for (int k = 0; k < NP; k++) begin
            if (mask[k]) begin
                chk(e_lab[k], 32'(res_o[k*DW +: DW]), 32'(e_res[k]));
                chk(e_we[k] ? "R10" : "R9", 32'(stat_o[k*TW +: TW]), 32'(e_stat[k]));
                chk("R9", 32'(wr_en_o[k]), 32'(e_we[k]));
                chk("R12", 32'(stat_upd_o[k]), 32'd1);
            end else begin
                chk("R2", 32'(res_o[k*DW +: DW]), 32'(e_res[k]));
                chk("R11", 32'(stat_o[k*TW +: TW]), 32'(e_stat[k]));
                chk("R2", 32'(wr_en_o[k]), 32'd0);
                chk("R2", 32'(stat_upd_o[k]), 32'd0);
            end
        end
        issue_i = '0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < NP; k++) begin
            e_res[k] = '0; e_stat[k] = '0; e_we[k] = 1'b0; e_lab[k] = "";
            for (int i = 0; i < 3; i++) begin
                m_v[k][i] = 1'b0; m_r[k][i] = '0; m_t[k][i] = '0;
            end
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'(res_o), 32'd0);
        chk("R1", 32'(res_o >> 32), 32'd0);
        chk("R1", 32'({wr_en_o, stat_upd_o}), 32'd0);
        chk("R1", 32'(stat_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'({wr_en_o, stat_upd_o}), 32'd0);

        // R3/R9: adder fill, then first valid return
        repeat (4) step(4'b0001, 2'b00);
        // R2: idle clocks hold everything
        repeat (3) step(4'b0000, 2'b00);
        step(4'b0001, 2'b00);
        // R7: graphics returns the previous issue
        repeat (3) step(4'b0100, 2'b11);
        // R4: single-source multiplier fills at three
        repeat (4) step(4'b0010, 2'b01);
        // R6: 3 -> 2, then R5 steady double, then R6 2 -> 3 empty
        step(4'b0010, 2'b11);
        step(4'b0010, 2'b10);
        step(4'b0010, 2'b00);
        step(4'b0010, 2'b00);
        // R8: load ignores precision
        repeat (4) step(4'b1000, 2'b11);
        // R11: mixed masks with random codes
        for (int n = 0; n < 400; n++) begin
            step(NP'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule